// File: doc/BRIEF.md
# Guaranteed-Write Calibration Sequencer

This block performs the first training step of a DDR-style memory interface, before any read or write timing is known. For each pass it issues four write commands whose data, address, bank and command lines stay constant for the whole burst. The write strobe is enabled for a window that opens a few cycles before the first write and closes a few cycles after the last burst, so the writes land even though no timing calibration has been done yet. A series of back-to-back reads to alternating banks follows. The reads return one constant stream followed by its complement, and an external read checker judges that stream.

Each pass uses one strobe-to-clock alignment setting, which is driven on `align_sel`. When the checker reports a failure, the sequencer moves to the next setting and runs the pass again. The sweep stops at the first setting that passes and reports it with `done`. If every setting fails, `fail` is raised instead. A programmable idle gap separates the write phase from the read phase, and one pass from the next.

Top module: `gw_cal_seq`

## Requirements
- R1: While reset is high and after it is released, the outputs idle as follows: `mem_cs_n`=1, `mem_cmd`=NOP (3'b111), `strobe_en`=0, `busy`=0, `done`=0, `fail`=0, `align_sel`=0. A reset in the middle of a sweep returns the outputs to this state.
- R2: Each pass issues exactly four write commands (`mem_cmd`=3'b100), in this order of (bank, column): (0,0), (0,1), (HI_BANK,0), (HI_BANK,1). Consecutive write commands are exactly BURST_LEN cycles apart.
- R3: A burst to bank 0 drives a word with every even data bit 0 and every odd data bit 1. A burst to bank HI_BANK drives the bitwise complement of that word. While the strobe window is open, `wr_data`, `mem_bank`, `mem_col` and `mem_cmd` change only on a command cycle.
- R4: `strobe_en` rises exactly STRB_PRE cycles before the first write command of a pass and stays high without a break. Its first low cycle comes BURST_LEN+STRB_POST cycles after the fourth write command. It is only ever high while `mem_cmd` is WRITE.
- R5: `mem_cs_n` is low for exactly one cycle per command, and only when `mem_cmd` is not NOP.
- R6: Each pass then issues four read commands (`mem_cmd`=3'b101), BURST_LEN cycles apart, in this order of (bank, column): (0,0), (HI_BANK,0), (0,1), (HI_BANK,1).
- R7: The first read command of a pass comes exactly `cfg_gap` cycles after the first cycle in which `strobe_en` is low again. A value of 0 means no idle cycles.
- R8: After a failing check, the next pass runs with `align_sel` raised by one and held constant across all of that pass's commands. If the check was sampled at clock edge e, `strobe_en` of the next pass first shows high after edge e+1+`cfg_gap`.
- R9: A check with `chk_pass`=1 ends the sweep. `done` goes high, `align_sel` holds the passing setting, `busy` goes low, no further commands are issued, and these values hold until the next start.
- R10: If the check of the last setting (NUM_ALIGN-1) fails, `fail` goes high while `done` stays low, and no further commands are issued.
- R11: `chk_valid` is ignored outside the wait that follows the fourth read of a pass.
- R12: If `start` is sampled at edge e while the block is idle, done or failed, `done` and `fail` clear, `busy` rises, and `strobe_en` is high after edge e+1. The sweep restarts at setting 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep at setting 0 (sampled when not busy) |
| cfg_gap | input | GAP_W | Idle cycles before the read phase and before each new pass |
| chk_valid | input | 1 | Read checker verdict is valid |
| chk_pass | input | 1 | Read checker verdict: 1 = pass |
| mem_cmd | output | 3 | Command code: NOP 3'b111, WRITE 3'b100, READ 3'b101 |
| mem_cs_n | output | 1 | Chip select, active low, one cycle per command |
| mem_bank | output | BANK_W | Bank address |
| mem_col | output | COL_W | Column address |
| wr_data | output | DATA_W | Write data, constant over each burst |
| strobe_en | output | 1 | Write strobe toggle enable |
| align_sel | output | ALIGN_W | Current strobe-to-clock alignment setting |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep found a passing setting |
| fail | output | 1 | Every setting failed |

## Verification
The bench builds the block with an 8-bit data path, a burst of 4 beats, three alignment settings, a pre-strobe lead of 2 and a post-strobe tail of 3. Because the lead and the tail differ, an error that swaps them shows up in the window edges. Three settings are enough to reach a pass on the first, middle and last setting, and a fail after the last one. Gap values from 0 to 5 exercise both the skipped-gap and the counted-gap paths, between phases and between passes. One scenario sends a spurious passing verdict during a write phase to show that it is ignored.

// File: rtl/gw_cal_pkg.sv
package gw_cal_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WPRE,
    PH_WSLOT,
    PH_WPOST,
    PH_GAPR,
    PH_RSLOT,
    PH_WAIT,
    PH_GAPA,
    PH_DONE,
    PH_FAIL
  } phase_e;

  localparam logic [2:0] CMD_NOP   = 3'b111;
  localparam logic [2:0] CMD_WRITE = 3'b100;
  localparam logic [2:0] CMD_READ  = 3'b101;

  localparam logic [1:0] LAST_SLOT = 2'd3;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gw_pattern_gen.sv
module gw_pattern_gen #(
  parameter int DATA_W = 16
) (
  input  logic              ones,
  output logic [DATA_W-1:0] word
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if ((i % 2) == 1) begin : g_odd
      assign word[i] = ~ones;
    end else begin : g_even
      assign word[i] = ones;
    end
  end

endmodule

// File: rtl/gw_slot_map.sv
module gw_slot_map #(
  parameter int BANK_W  = 3,
  parameter int COL_W   = 10,
  parameter int HI_BANK = 3
) (
  input  logic              rd_phase,
  input  logic [1:0]        slot,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col,
  output logic              ones
);

  logic hi_sel;
  logic col_bit;

  // Writes step the column first, reads alternate the bank first.
  always_comb begin
    hi_sel  = rd_phase ? slot[0] : slot[1];
    col_bit = rd_phase ? slot[1] : slot[0];
    bank    = hi_sel ? BANK_W'(HI_BANK) : '0;
    col     = COL_W'(col_bit);
    ones    = hi_sel;
  end

endmodule

// File: rtl/gw_seq_fsm.sv
module gw_seq_fsm
  import gw_cal_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int NUM_ALIGN = 4,
  parameter int STRB_PRE  = 2,
  parameter int STRB_POST = 2,
  parameter int GAP_W     = 8,
  parameter int ALIGN_W   = 2,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               chk_valid,
  input  logic               chk_pass,
  input  logic [GAP_W-1:0]   cfg_gap,
  output phase_e             phase,
  output logic [1:0]         slot,
  output logic [ALIGN_W-1:0] align,
  output logic               first_beat
);

  localparam logic [CNT_W-1:0]   BL_LD      = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0]   PRE_LD     = CNT_W'(STRB_PRE - 1);
  localparam logic [CNT_W-1:0]   POST_LD    = CNT_W'(STRB_POST - 1);
  localparam logic [ALIGN_W-1:0] ALIGN_LAST = ALIGN_W'(NUM_ALIGN - 1);

  phase_e             phase_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [1:0]         slot_n;
  logic [ALIGN_W-1:0] align_n;
  logic               cnt_zero;
  logic               gap_zero;
  logic [CNT_W-1:0]   gap_ld;

  assign cnt_zero   = (cnt == '0);
  assign gap_zero   = (cfg_gap == '0);
  assign gap_ld     = CNT_W'(cfg_gap) - CNT_W'(1);
  assign first_beat = ((phase == PH_WSLOT) || (phase == PH_RSLOT)) && (cnt == BL_LD);

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt_zero ? cnt : cnt - CNT_W'(1);
    slot_n  = slot;
    align_n = align;
    case (phase)
      PH_IDLE, PH_DONE, PH_FAIL: begin
        if (start) begin
          phase_n = PH_WPRE;
          cnt_n   = PRE_LD;
          slot_n  = '0;
          align_n = '0;
        end
      end
      PH_WPRE: begin
        if (cnt_zero) begin
          phase_n = PH_WSLOT;
          cnt_n   = BL_LD;
        end
      end
      PH_WSLOT: begin
        if (cnt_zero) begin
          if (slot == LAST_SLOT) begin
            phase_n = PH_WPOST;
            cnt_n   = POST_LD;
          end else begin
            slot_n = slot + 2'd1;
            cnt_n  = BL_LD;
          end
        end
      end
      PH_WPOST: begin
        if (cnt_zero) begin
          slot_n = '0;
          if (gap_zero) begin
            phase_n = PH_RSLOT;
            cnt_n   = BL_LD;
          end else begin
            phase_n = PH_GAPR;
            cnt_n   = gap_ld;
          end
        end
      end
      PH_GAPR: begin
        if (cnt_zero) begin
          phase_n = PH_RSLOT;
          cnt_n   = BL_LD;
        end
      end
      PH_RSLOT: begin
        if (cnt_zero) begin
          if (slot == LAST_SLOT) begin
            phase_n = PH_WAIT;
          end else begin
            slot_n = slot + 2'd1;
            cnt_n  = BL_LD;
          end
        end
      end
      PH_WAIT: begin
        if (chk_valid) begin
          if (chk_pass) begin
            phase_n = PH_DONE;
          end else if (align == ALIGN_LAST) begin
            phase_n = PH_FAIL;
          end else begin
            align_n = align + ALIGN_W'(1);
            slot_n  = '0;
            if (gap_zero) begin
              phase_n = PH_WPRE;
              cnt_n   = PRE_LD;
            end else begin
              phase_n = PH_GAPA;
              cnt_n   = gap_ld;
            end
          end
        end
      end
      PH_GAPA: begin
        if (cnt_zero) begin
          phase_n = PH_WPRE;
          cnt_n   = PRE_LD;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      slot  <= '0;
      align <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      slot  <= slot_n;
      align <= align_n;
    end
  end

endmodule

// File: rtl/gw_cal_seq.sv
module gw_cal_seq
  import gw_cal_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8,
  parameter int NUM_ALIGN = 4,
  parameter int STRB_PRE  = 2,
  parameter int STRB_POST = 2,
  parameter int GAP_W     = 8,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int HI_BANK   = 3,
  localparam int ALIGN_W  = (NUM_ALIGN > 1) ? $clog2(NUM_ALIGN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               chk_valid,
  input  logic               chk_pass,
  output logic [2:0]         mem_cmd,
  output logic               mem_cs_n,
  output logic [BANK_W-1:0]  mem_bank,
  output logic [COL_W-1:0]   mem_col,
  output logic [DATA_W-1:0]  wr_data,
  output logic               strobe_en,
  output logic [ALIGN_W-1:0] align_sel,
  output logic               busy,
  output logic               done,
  output logic               fail
);

  localparam int CNT_W = max2(max2(GAP_W, $clog2(BURST_LEN + 1)),
                              max2($clog2(STRB_PRE + 1), $clog2(STRB_POST + 1)));

  phase_e             phase;
  logic [1:0]         slot;
  logic [ALIGN_W-1:0] align;
  logic               first_beat;
  logic               wr_ph;
  logic               rd_ph;
  logic               idle_ph;
  logic [BANK_W-1:0]  map_bank;
  logic [COL_W-1:0]   map_col;
  logic               map_ones;
  logic [DATA_W-1:0]  pat_word;

  gw_seq_fsm #(
    .BURST_LEN (BURST_LEN),
    .NUM_ALIGN (NUM_ALIGN),
    .STRB_PRE  (STRB_PRE),
    .STRB_POST (STRB_POST),
    .GAP_W     (GAP_W),
    .ALIGN_W   (ALIGN_W),
    .CNT_W     (CNT_W)
  ) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .chk_valid  (chk_valid),
    .chk_pass   (chk_pass),
    .cfg_gap    (cfg_gap),
    .phase      (phase),
    .slot       (slot),
    .align      (align),
    .first_beat (first_beat)
  );

  gw_slot_map #(
    .BANK_W  (BANK_W),
    .COL_W   (COL_W),
    .HI_BANK (HI_BANK)
  ) i_map (
    .rd_phase (rd_ph),
    .slot     (slot),
    .bank     (map_bank),
    .col      (map_col),
    .ones     (map_ones)
  );

  gw_pattern_gen #(
    .DATA_W (DATA_W)
  ) i_pat (
    .ones (map_ones),
    .word (pat_word)
  );

  assign wr_ph   = (phase == PH_WPRE) || (phase == PH_WSLOT) || (phase == PH_WPOST);
  assign rd_ph   = (phase == PH_RSLOT);
  assign idle_ph = (phase == PH_IDLE) || (phase == PH_DONE) || (phase == PH_FAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cmd   <= CMD_NOP;
      mem_cs_n  <= 1'b1;
      mem_bank  <= '0;
      mem_col   <= '0;
      wr_data   <= '0;
      strobe_en <= 1'b0;
      align_sel <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      mem_cmd   <= wr_ph ? CMD_WRITE : (rd_ph ? CMD_READ : CMD_NOP);
      mem_cs_n  <= ~first_beat;
      mem_bank  <= (wr_ph || rd_ph) ? map_bank : '0;
      mem_col   <= (wr_ph || rd_ph) ? map_col : '0;
      wr_data   <= wr_ph ? pat_word : '0;
      strobe_en <= wr_ph;
      align_sel <= align;
      busy      <= ~idle_ph;
      done      <= (phase == PH_DONE);
      fail      <= (phase == PH_FAIL);
    end
  end

endmodule

// File: rtl/gw_cal_seq_chk.sv
module gw_cal_seq_chk
  import gw_cal_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int ALIGN_W   = 2,
  parameter int NUM_ALIGN = 4,
  parameter int BURST_LEN = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         mem_cmd,
  input logic               mem_cs_n,
  input logic [BANK_W-1:0]  mem_bank,
  input logic [COL_W-1:0]   mem_col,
  input logic [DATA_W-1:0]  wr_data,
  input logic               strobe_en,
  input logic [ALIGN_W-1:0] align_sel,
  input logic               busy,
  input logic               done,
  input logic               fail
);

  function automatic logic [DATA_W-1:0] pair_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i + 1 < DATA_W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0]  PAIR       = pair_mask();
  localparam logic [ALIGN_W-1:0] ALIGN_LAST = ALIGN_W'(NUM_ALIGN - 1);
  localparam bit                 MULTI_BEAT = (BURST_LEN > 1);

  AST_CS_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (mem_cmd != CMD_NOP)); // R5

  AST_CS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (MULTI_BEAT && !mem_cs_n) |=> mem_cs_n); // R5

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strobe_en && $past(strobe_en) && mem_cs_n) |->
      ($stable(wr_data) && $stable(mem_bank) && $stable(mem_col) && $stable(mem_cmd))); // R3

  AST_ODD_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    strobe_en |-> (((wr_data ^ (wr_data >> 1)) & PAIR) == PAIR)); // R3

  AST_STROBE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe_en |-> (mem_cmd == CMD_WRITE)); // R4

  AST_ALIGN_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(busy)) |-> $stable(align_sel)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && !busy && !fail)); // R9

  AST_FAIL_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> ((align_sel == ALIGN_LAST) && !done && mem_cs_n)); // R10

endmodule

bind gw_cal_seq gw_cal_seq_chk #(
  .DATA_W    (DATA_W),
  .BANK_W    (BANK_W),
  .COL_W     (COL_W),
  .ALIGN_W   (ALIGN_W),
  .NUM_ALIGN (NUM_ALIGN),
  .BURST_LEN (BURST_LEN)
) i_gw_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_cmd   (mem_cmd),
  .mem_cs_n  (mem_cs_n),
  .mem_bank  (mem_bank),
  .mem_col   (mem_col),
  .wr_data   (wr_data),
  .strobe_en (strobe_en),
  .align_sel (align_sel),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/test_gw_cal_seq.sv
`timescale 1ns/1ps
module test_gw_cal_seq;

  localparam int DW = 8, BL = 4, NA = 3, PRE = 2, POST = 3;
  localparam int GW = 8, BW = 3, CW = 10, HB = 3, AW = 2;
  localparam logic [2:0] NOP = 3'b111, WR = 3'b100, RD = 3'b101;

  // {pass mask[14:12], gap[11:4], spurious[3], expect done[2], expect index[1:0]}
  localparam logic [14:0] VEC [6] = '{
    {3'b001, 8'd3, 1'b0, 1'b1, 2'd0},
    {3'b100, 8'd0, 1'b0, 1'b1, 2'd2},
    {3'b000, 8'd5, 1'b0, 1'b0, 2'd0},
    {3'b010, 8'd1, 1'b1, 1'b1, 2'd1},
    {3'b110, 8'd2, 1'b0, 1'b1, 2'd1},
    {3'b111, 8'd0, 1'b0, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [GW-1:0] cfg_gap = '0;
  logic chk_valid = 1'b0;
  logic chk_pass = 1'b0;
  logic [2:0] mem_cmd;
  logic mem_cs_n;
  logic [BW-1:0] mem_bank;
  logic [CW-1:0] mem_col;
  logic [DW-1:0] wr_data;
  logic strobe_en;
  logic [AW-1:0] align_sel;
  logic busy, done, fail;

  always #2.5 clk = ~clk;

  gw_cal_seq #(
    .DATA_W(DW), .BURST_LEN(BL), .NUM_ALIGN(NA), .STRB_PRE(PRE), .STRB_POST(POST),
    .GAP_W(GW), .BANK_W(BW), .COL_W(CW), .HI_BANK(HB)
  ) i_gw_cal_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_gap(cfg_gap),
    .chk_valid(chk_valid), .chk_pass(chk_pass),
    .mem_cmd(mem_cmd), .mem_cs_n(mem_cs_n), .mem_bank(mem_bank), .mem_col(mem_col),
    .wr_data(wr_data), .strobe_en(strobe_en), .align_sel(align_sel),
    .busy(busy), .done(done), .fail(fail)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Observation log, filled at the falling edge
  int ncmd, nrise, nfall, hold_err, cs_err;
  int c_cyc [32];
  logic [2:0] c_cmd [32];
  logic [BW-1:0] c_bank [32];
  logic [CW-1:0] c_col [32];
  logic [DW-1:0] c_data [32];
  logic [AW-1:0] c_al [32];
  int rise_c [8];
  int fall_c [8];
  int chk_c [8];
  logic prev_se = 1'b0;
  logic prev_csl = 1'b0;
  logic [DW-1:0] prev_d;
  logic [BW-1:0] prev_b;
  logic [CW-1:0] prev_c;

  always @(negedge clk) begin
    if (rst) begin
      prev_se = 1'b0;
      prev_csl = 1'b0;
    end else begin
      if (!mem_cs_n && ncmd < 32) begin
        c_cyc[ncmd] = cyc; c_cmd[ncmd] = mem_cmd; c_bank[ncmd] = mem_bank;
        c_col[ncmd] = mem_col; c_data[ncmd] = wr_data; c_al[ncmd] = align_sel;
        ncmd++;
      end
      if (!mem_cs_n && (prev_csl || mem_cmd == NOP)) cs_err++;
      if (strobe_en && prev_se && mem_cs_n &&
          (wr_data != prev_d || mem_bank != prev_b || mem_col != prev_c)) hold_err++;
      if (strobe_en && !prev_se && nrise < 8) begin rise_c[nrise] = cyc; nrise++; end
      if (!strobe_en && prev_se && nfall < 8) begin fall_c[nfall] = cyc; nfall++; end
      prev_se = strobe_en;
      prev_csl = !mem_cs_n;
      prev_d = wr_data; prev_b = mem_bank; prev_c = mem_col;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input bit ones);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = ones ? ~i[0] : i[0];
    return int'(w);
  endfunction

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clear_log();
    ncmd = 0; nrise = 0; nfall = 0; hold_err = 0; cs_err = 0;
  endtask

  task automatic run_vec(input logic [14:0] v);
    logic [2:0] mask;
    int gap, np, k, cd, pass_i, guard, base, i;
    bit spur, spur_done, edone;
    int eidx;
    mask = v[14:12]; gap = int'(v[11:4]); spur = v[3]; edone = v[2]; eidx = int'(v[1:0]);
    clear_log();
    cfg_gap = v[11:4];
    @(negedge clk); #1;
    start = 1'b1; k = cyc;
    @(negedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    check("R12", "cycles to strobe", (cyc == k + 2 && strobe_en) ? 1 : 0, 1);
    check("R12", "done/fail cleared, busy", {done, fail, busy}, 3'b001);
    pass_i = 0; cd = -1; spur_done = 0; guard = 0;
    while (!(done || fail) && guard < 5000) begin
      @(negedge clk); #1;
      guard++;
      chk_valid = 1'b0;
      if (spur && !spur_done && ncmd >= 1) begin
        chk_valid = 1'b1; chk_pass = 1'b1; spur_done = 1;
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          chk_valid = 1'b1; chk_pass = mask[align_sel];
          chk_c[pass_i] = cyc; pass_i++; cd = -1;
        end
      end else if (cd < 0 && ncmd >= 8 * (pass_i + 1)) begin
        cd = BL + 1;
      end
    end
    chk_valid = 1'b0;
    np = edone ? eidx + 1 : NA;
    check("R2", "command count", ncmd, 8 * np);
    check("R4", "strobe windows", nrise, np);
    for (int p = 0; p < np && 8 * p + 7 < ncmd; p++) begin
      base = 8 * p;
      for (int w = 0; w < 4; w++) begin
        i = base + w;
        check("R2", "write cmd", int'(c_cmd[i]), int'(WR));
        check("R2", "write bank", int'(c_bank[i]), (w >= 2) ? HB : 0);
        check("R2", "write col", int'(c_col[i]), w % 2);
        check("R3", "write data", int'(c_data[i]), pat(w >= 2));
        if (w > 0) check("R2", "write spacing", c_cyc[i] - c_cyc[i-1], BL);
      end
      for (int r = 0; r < 4; r++) begin
        i = base + 4 + r;
        check("R6", "read cmd", int'(c_cmd[i]), int'(RD));
        check("R6", "read bank", int'(c_bank[i]), (r % 2 == 1) ? HB : 0);
        check("R6", "read col", int'(c_col[i]), r / 2);
        check("R8", "align during pass", int'(c_al[i]), p);
        if (r > 0) check("R6", "read spacing", c_cyc[i] - c_cyc[i-1], BL);
      end
      check("R8", "align on first write", int'(c_al[base]), p);
      if (p < nrise) check("R4", "strobe lead", rise_c[p], c_cyc[base] - PRE);
      if (p < nfall) begin
        check("R4", "strobe tail", fall_c[p], c_cyc[base + 3] + BL + POST);
        check("R7", "read gap", c_cyc[base + 4], fall_c[p] + gap);
      end
      if (p > 0 && p < nrise) check("R8", "next pass start", rise_c[p], chk_c[p-1] + 2 + gap);
    end
    check("R3", "held lines in window", hold_err, 0);
    check("R5", "chip select pulses", cs_err, 0);
    if (edone) begin
      check("R9", "done/fail/busy", {done, fail, busy}, 3'b100);
      check("R9", "passing index", int'(align_sel), eidx);
      if (spur) check("R11", "spurious verdict ignored", int'(align_sel), eidx);
    end else begin
      check("R10", "done/fail/busy", {done, fail, busy}, 3'b010);
      check("R10", "last index", int'(align_sel), NA - 1);
    end
    k = ncmd;
    repeat (20) @(negedge clk);
    #1;
    check(edone ? "R9" : "R10", "quiet after end", ncmd, k);
    check(edone ? "R9" : "R10", "status held", {done, fail}, edone ? 2'b10 : 2'b01);
  endtask

  initial begin
    clear_log();
    repeat (5) @(negedge clk);
    #1;
    check("R1", "cs_n in reset", int'(mem_cs_n), 1);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1", "cmd after reset", int'(mem_cmd), int'(NOP));
    check("R1", "status after reset", {strobe_en, busy, done, fail}, 4'b0000);
    check("R1", "align after reset", int'(align_sel), 0);
    check("R1", "cs_n after reset", int'(mem_cs_n), 1);

    // Reset in the middle of a sweep
    cfg_gap = 8'd2;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check("R1", "busy before mid reset", int'(busy), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1", "mid reset outputs", {mem_cs_n, strobe_en, busy, done, fail}, 5'b10000);
    check("R1", "mid reset cmd", int'(mem_cmd), int'(NOP));
    rst = 1'b0;
    @(negedge clk); #1;

    foreach (VEC[n]) run_vec(VEC[n]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule